// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Register Bank

This block holds the mask and priority registers of an interrupt controller and turns every register write into a stream of per-source enable and disable events. Each register has its own set address and its own clear address. A write to the set address ORs bits in, and a write to the clear address removes bits. The last priority register has only a set address, and a write there loads the data directly. Address decode ignores the top three address bits, so aliased address windows reach the same register. A read from either address of a register returns its stored value.

After an accepted write, only the fields whose value changed raise events. There is one event per clock cycle, in ascending field order. A field can name a group rather than a source. In that case the walker follows the group's member chain, one member per cycle, and emits an event for every member that has a vector. The block is busy for the whole walk and drops writes that arrive during it. A downstream pending aggregator consumes the events.

Default source map: ids 1 to 15 have vectors. Mask register 0 field k holds id k+1 for k<15, and id 0 in field 15. Mask register 1 holds ids 16, 17 and 20 in fields 0, 1 and 2, and id 0 in its other fields. Priority register 2 holds ids 1, 2, 17 and 21. Priority register 3 (set-only) holds ids 5, 6, 7 and 18. The chains are 16→3→4→5, 17→8→9 and 18→19→12. Ids 16 to 19 have no vector, and ids 20 and 21 are unused.

Top module: `sc_mask_bank`

## Requirements
- R1: The register address compare uses only address bits 28:0. Register r has its set address at BASE+8r and its clear address at BASE+8r+4. Any value of bits 31:29 reaches the same register.
- R2: A write to a set address ORs the data into the register. A write to a clear address clears the register bits that are 1 in the data.
- R3: Register 3 has no clear address. A write to its set address replaces the stored value with the data.
- R4: A read from either address of a register returns its value. A read from an unmapped address returns 0. A write to an unmapped address changes nothing and starts no events.
- R5: Mask registers (0 and 1) have one-bit fields, and field k sits at bit 15-k. Each changed field produces one event, with ev_enable equal to the field's new bit. Unchanged fields produce none.
- R6: Priority registers (2 and 3) have 4-bit fields, and field k sits at bits 15-4k down to 12-4k. A field that changes produces an event with ev_enable=1 if its new value is nonzero, including a change from one nonzero value to another.
- R7: Events start in the cycle after the accepted write and are processed one id per cycle in ascending field order. busy stays high for exactly the number of processed ids.
- R8: A field holding id 0, or an unused id with no vector and no chain successor, uses one busy cycle and produces no event.
- R9: A group id produces no event and hands its chain successor to the next cycle. Members reached through a group emit their own event and continue along the chain until a member has no successor.
- R10: A source with a vector that is reached directly from a field does not continue to its chain successor.
- R11: A write that arrives while busy is high is dropped and leaves all registers unchanged.
- R12: After reset all registers read 0, busy is low and no event is signalled.
- R13: The source map and chains are those listed in the description above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 32 | Bus address for reads and writes |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_data | output | 16 | Value of the addressed register, 0 when unmapped |
| busy | output | 1 | Event walk in progress; writes are dropped |
| ev_valid | output | 1 | Event present this cycle |
| ev_id | output | 5 | Source id of the event |
| ev_enable | output | 1 | 1 = enable, 0 = disable |

## Verification
On every cycle the assertions check that events appear only while the walk is busy and carry a vectored id, that registers change only on a write accepted while idle, and that a walk starts only after a write. Only the bench's scenarios can show the actual values and ordering: the set, clear and load arithmetic, alias decode, field bit positions, nonzero-to-nonzero priority changes, ignored ids, nested group chains, and the exact length of each walk. For these the bench compares against a reference model of the register values and of the source map.

// File: rtl/sc_bank_pkg.sv
package sc_bank_pkg;

  localparam int ID_W = 5;
  typedef logic [ID_W-1:0] src_id_t;

  typedef enum logic [1:0] {
    WR_SET  = 2'd0,
    WR_CLR  = 2'd1,
    WR_LOAD = 2'd2
  } wr_kind_e;

  // Source id held by field k of register r.
  function automatic src_id_t field_src(int r, int k);
    src_id_t id;
    id = '0;
    case (r)
      0: if (k < 15) id = src_id_t'(k + 1);
      1: case (k)
           0: id = 5'd16;
           1: id = 5'd17;
           2: id = 5'd20;
           default: id = '0;
         endcase
      2: case (k)
           0: id = 5'd1;
           1: id = 5'd2;
           2: id = 5'd17;
           3: id = 5'd21;
           default: id = '0;
         endcase
      3: case (k)
           0: id = 5'd5;
           1: id = 5'd6;
           2: id = 5'd7;
           3: id = 5'd18;
           default: id = '0;
         endcase
      default: id = '0;
    endcase
    return id;
  endfunction

  function automatic logic src_has_vec(src_id_t id);
    return (id >= 5'd1) && (id <= 5'd15);
  endfunction

  // Next member along a group chain; 0 ends the chain.
  function automatic src_id_t src_next(src_id_t id);
    case (id)
      5'd16:   return 5'd3;
      5'd3:    return 5'd4;
      5'd4:    return 5'd5;
      5'd17:   return 5'd8;
      5'd8:    return 5'd9;
      5'd18:   return 5'd19;
      5'd19:   return 5'd12;
      default: return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/sc_addr_decode.sv
module sc_addr_decode
  import sc_bank_pkg::*;
#(
  parameter int              NREG       = 4,
  parameter int              ADDR_W     = 32,
  parameter logic [31:0]     BASE       = 32'hA400_0100,
  parameter int              STRIDE     = 8,
  parameter logic [31:0]     ALIAS_MASK = 32'h1FFF_FFFF,
  parameter bit              LAST_SET_ONLY = 1'b1,
  localparam int             IDX_W      = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output wr_kind_e          kind
);

  localparam logic [ADDR_W-1:0] AMASK = ADDR_W'(ALIAS_MASK);

  logic [NREG-1:0] set_hit;
  logic [NREG-1:0] clr_hit;
  logic [NREG-1:0] set_only;
  logic [ADDR_W-1:0] addr_m;

  assign addr_m = addr & AMASK;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BASE) + ADDR_W'(r * STRIDE);
    localparam logic [ADDR_W-1:0] CLR_A = SET_A + ADDR_W'(4);
    localparam bit HAS_CLR = !(LAST_SET_ONLY && (r == NREG - 1));
    assign set_only[r] = !HAS_CLR;
    assign set_hit[r]  = (addr_m == (SET_A & AMASK));
    if (HAS_CLR) begin : g_clr
      assign clr_hit[r] = (addr_m == (CLR_A & AMASK));
    end else begin : g_noclr
      assign clr_hit[r] = 1'b0;
    end
  end

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    kind = WR_SET;
    for (int r = NREG - 1; r >= 0; r--) begin
      if (set_hit[r] || clr_hit[r]) begin
        hit = 1'b1;
        idx = IDX_W'(r);
        if (clr_hit[r])       kind = WR_CLR;
        else if (set_only[r]) kind = WR_LOAD;
        else                  kind = WR_SET;
      end
    end
  end

endmodule

// File: rtl/sc_reg_store.sv
module sc_reg_store
  import sc_bank_pkg::*;
#(
  parameter int  NREG    = 4,
  parameter int  NMASK   = 2,
  parameter int  REG_W   = 16,
  parameter int  FIELD_W = 4,
  localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int NPF     = REG_W / FIELD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_go,
  input  logic [IDX_W-1:0]      idx,
  input  wr_kind_e              kind,
  input  logic [REG_W-1:0]      wdata,
  output logic [REG_W-1:0]      rd_val,
  output logic [REG_W-1:0]      chg,
  output logic [REG_W-1:0]      en,
  output logic [NREG*REG_W-1:0] regs_flat
);

  logic [REG_W-1:0] reg_q [NREG];
  logic [REG_W-1:0] reg_d [NREG];
  logic [REG_W-1:0] old_v;
  logic [REG_W-1:0] new_v;
  logic             is_prio;
  logic [REG_W-1:0] m_chg, m_en, p_chg, p_en;

  assign old_v   = reg_q[idx];
  assign rd_val  = old_v;
  assign is_prio = (int'(idx) >= NMASK);

  always_comb begin
    case (kind)
      WR_CLR:  new_v = old_v & ~wdata;
      WR_LOAD: new_v = wdata;
      default: new_v = old_v | wdata;
    endcase
  end

  for (genvar k = 0; k < REG_W; k++) begin : g_fld
    assign m_chg[k] = old_v[REG_W-1-k] ^ new_v[REG_W-1-k];
    assign m_en[k]  = new_v[REG_W-1-k];
    if (k < NPF) begin : g_pf
      assign p_chg[k] = old_v[(NPF-1-k)*FIELD_W +: FIELD_W] !=
                        new_v[(NPF-1-k)*FIELD_W +: FIELD_W];
      assign p_en[k]  = |new_v[(NPF-1-k)*FIELD_W +: FIELD_W];
    end else begin : g_nopf
      assign p_chg[k] = 1'b0;
      assign p_en[k]  = 1'b0;
    end
  end

  assign chg = is_prio ? p_chg : m_chg;
  assign en  = is_prio ? p_en  : m_en;

  always_comb begin
    for (int r = 0; r < NREG; r++) reg_d[r] = reg_q[r];
    if (wr_go) reg_d[idx] = new_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) reg_q[r] <= '0;
    end else if (wr_go) begin
      for (int r = 0; r < NREG; r++) reg_q[r] <= reg_d[r];
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_flat
    assign regs_flat[r*REG_W +: REG_W] = reg_q[r];
  end

endmodule

// File: rtl/sc_event_walker.sv
module sc_event_walker
  import sc_bank_pkg::*;
#(
  parameter int  NF    = 16,
  parameter int  IDX_W = 2,
  localparam int KW    = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic [NF-1:0]    load_chg,
  input  logic [NF-1:0]    load_en,
  output logic             busy,
  output logic             ev_valid,
  output src_id_t          ev_id,
  output logic             ev_enable
);

  logic [NF-1:0]    pend_q, pend_d;
  logic [NF-1:0]    en_q, en_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             chain_q, chain_d;
  src_id_t          cid_q, cid_d;
  logic             cen_q, cen_d;

  logic             pick_valid;
  logic [KW-1:0]    pick_k;
  src_id_t          cur_id, nx_id;
  logic             cur_en, via_grp, hv, drop, active, go_next;

  always_comb begin
    pick_k = '0;
    for (int k = NF - 1; k >= 0; k--) begin
      if (pend_q[k]) pick_k = KW'(k);
    end
  end
  assign pick_valid = |pend_q;

  always_comb begin
    if (chain_q) begin
      cur_id  = cid_q;
      cur_en  = cen_q;
      via_grp = 1'b1;
    end else begin
      cur_id  = field_src(int'(idx_q), int'(pick_k));
      cur_en  = en_q[pick_k];
      via_grp = 1'b0;
    end
  end

  assign active  = chain_q | pick_valid;
  assign hv      = src_has_vec(cur_id);
  assign nx_id   = src_next(cur_id);
  assign drop    = (cur_id == '0) || (!hv && nx_id == '0);
  assign go_next = active && !drop && (via_grp || !hv) && (nx_id != '0);

  assign busy      = active;
  assign ev_valid  = active && !drop && hv;
  assign ev_id     = ev_valid ? cur_id : '0;
  assign ev_enable = ev_valid & cur_en;

  always_comb begin
    pend_d  = pend_q;
    en_d    = en_q;
    idx_d   = idx_q;
    chain_d = go_next;
    cid_d   = go_next ? nx_id : '0;
    cen_d   = go_next ? cur_en : 1'b0;
    if (!chain_q && pick_valid) pend_d[pick_k] = 1'b0;
    if (load) begin
      pend_d = load_chg;
      en_d   = load_en;
      idx_d  = load_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      idx_q   <= '0;
      chain_q <= 1'b0;
      cid_q   <= '0;
      cen_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      chain_q <= chain_d;
      cid_q   <= cid_d;
      cen_q   <= cen_d;
      if (load) begin
        en_q  <= en_d;
        idx_q <= idx_d;
      end
    end
  end

endmodule

// File: rtl/sc_mask_bank.sv
module sc_mask_bank
  import sc_bank_pkg::*;
#(
  parameter int          NMASK      = 2,
  parameter int          NPRIO      = 2,
  parameter int          REG_W      = 16,
  parameter int          FIELD_W    = 4,
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] BASE       = 32'hA400_0100,
  parameter int          STRIDE     = 8,
  parameter logic [31:0] ALIAS_MASK = 32'h1FFF_FFFF,
  localparam int         NREG       = NMASK + NPRIO,
  localparam int         IDX_W      = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              wr_en,
  output logic [REG_W-1:0]  rd_data,
  output logic              busy,
  output logic              ev_valid,
  output logic [ID_W-1:0]   ev_id,
  output logic              ev_enable
);

  logic                  hit;
  logic [IDX_W-1:0]      idx;
  wr_kind_e              kind;
  logic                  wr_go;
  logic [REG_W-1:0]      rd_val;
  logic [REG_W-1:0]      chg, en;
  logic [NREG*REG_W-1:0] regs_flat;

  sc_addr_decode #(
    .NREG(NREG), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE),
    .ALIAS_MASK(ALIAS_MASK), .LAST_SET_ONLY(1'b1)
  ) u_dec (
    .addr(addr), .hit(hit), .idx(idx), .kind(kind)
  );

  assign wr_go = wr_en && hit && !busy;

  sc_reg_store #(
    .NREG(NREG), .NMASK(NMASK), .REG_W(REG_W), .FIELD_W(FIELD_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .idx(idx), .kind(kind),
    .wdata(wr_data), .rd_val(rd_val), .chg(chg), .en(en),
    .regs_flat(regs_flat)
  );

  assign rd_data = hit ? rd_val : '0;

  sc_event_walker #(
    .NF(REG_W), .IDX_W(IDX_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .load(wr_go), .load_idx(idx),
    .load_chg(chg), .load_en(en), .busy(busy), .ev_valid(ev_valid),
    .ev_id(ev_id), .ev_enable(ev_enable)
  );

endmodule

// File: rtl/sc_mask_bank_chk.sv
module sc_mask_bank_chk #(
  parameter int FLAT_W = 64,
  parameter int ID_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              busy,
  input logic              ev_valid,
  input logic [ID_W-1:0]   ev_id,
  input logic [FLAT_W-1:0] regs_flat
);

  // R7: an event only appears inside a busy walk
  a_r7_event_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> busy);

  // R8: no event for id 0 or for ids without a vector (R13 map: 1..15)
  a_r8_vectored_only: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_id != '0) && (ev_id <= 15));

  // R11: a write during a walk leaves every register unchanged
  a_r11_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(regs_flat));

  // R4: registers never change without a write strobe
  a_r4_no_spurious_change: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));

  // R7: a walk starts only in the cycle after a write
  a_r7_walk_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

endmodule

bind sc_mask_bank sc_mask_bank_chk #(
  .FLAT_W(NREG*REG_W), .ID_W(sc_bank_pkg::ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
  .ev_valid(ev_valid), .ev_id(ev_id), .regs_flat(regs_flat)
);

// File: tb/sc_mask_bank_bench.sv
module sc_mask_bank_bench;

  localparam logic [31:0] BASE = 32'hA400_0100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] addr;
  logic [15:0] wr_data;
  logic        wr_en;
  logic [15:0] rd_data;
  logic        busy, ev_valid, ev_enable;
  logic [4:0]  ev_id;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_reg [4];
  int q_id[$];
  int q_en[$];
  int exp_steps;

  always #2 clk = ~clk;

  sc_mask_bank u_sc_mask_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_data(rd_data), .busy(busy), .ev_valid(ev_valid), .ev_id(ev_id),
    .ev_enable(ev_enable)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Source map from R13
  function automatic int b_src(int r, int k);
    if (r == 0) return (k < 15) ? k + 1 : 0;
    if (r == 1) return (k == 0) ? 16 : (k == 1) ? 17 : (k == 2) ? 20 : 0;
    if (r == 2) return (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 17 : (k == 3) ? 21 : 0;
    return (k == 0) ? 5 : (k == 1) ? 6 : (k == 2) ? 7 : (k == 3) ? 18 : 0;
  endfunction

  function automatic bit b_vec(int id);
    return id >= 1 && id <= 15;
  endfunction

  function automatic int b_next(int id);
    case (id)
      16: return 3;  3: return 4;  4: return 5;
      17: return 8;  8: return 9;
      18: return 19; 19: return 12;
      default: return 0;
    endcase
  endfunction

  // R8/R9/R10: expected walk for one changed field
  task automatic expand(input int id0, input int en);
    int id = id0;
    bit grp = 0;
    bit done = 0;
    while (!done) begin
      exp_steps++;
      if (id == 0 || (!b_vec(id) && b_next(id) == 0)) begin
        done = 1;
      end else begin
        if (b_vec(id)) begin
          q_id.push_back(id);
          q_en.push_back(en);
        end
        if ((grp || !b_vec(id)) && b_next(id) != 0) begin
          id = b_next(id);
          grp = 1;
        end else begin
          done = 1;
        end
      end
    end
  endtask

  function automatic logic [31:0] reg_addr(int r, bit clr, logic [2:0] al);
    return {al, 29'(BASE + 32'(r * 8 + (clr ? 4 : 0)))};
  endfunction

  task automatic read_check(input int r, input string req);
    logic [15:0] exp_v = m_reg[r];
    addr = reg_addr(r, 0, 3'($urandom));
    #1;
    check(rd_data == exp_v, req, "read set addr", rd_data, exp_v);
    if (r != 3) begin
      addr = reg_addr(r, 1, 3'($urandom));
      #1;
      check(rd_data == exp_v, req, "read clear addr", rd_data, exp_v);
    end
  endtask

  // kind: 0 set, 1 clear, 2 load. inject: second write while busy (R11)
  task automatic run_write(input int r, input int kind, input logic [15:0] d,
                           input logic [2:0] al, input bit inject, input string req);
    logic [15:0] ov = m_reg[r];
    logic [15:0] nv;
    int cyc = 0;
    int g_id[$];
    int g_en[$];
    nv = (kind == 0) ? (ov | d) : (kind == 1) ? (ov & ~d) : d;
    q_id.delete(); q_en.delete(); exp_steps = 0;
    for (int k = 0; k < 16; k++) begin
      if (r < 2) begin
        if (ov[15-k] != nv[15-k]) expand(b_src(r, k), int'(nv[15-k]));
      end else if (k < 4) begin
        if (ov[(3-k)*4 +: 4] != nv[(3-k)*4 +: 4])
          expand(b_src(r, k), int'(|nv[(3-k)*4 +: 4]));
      end
    end
    m_reg[r] = nv;
    @(negedge clk);
    addr = reg_addr(r, kind == 1, al);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    while (busy && cyc < 100) begin
      cyc++;
      if (ev_valid) begin
        g_id.push_back(int'(ev_id));
        g_en.push_back(int'(ev_enable));
      end
      if (inject && cyc == 1) begin
        addr = reg_addr((r + 1) % 4, 0, 3'd0);
        wr_data = 16'hFFFF;
        wr_en = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    check(cyc == exp_steps, {req, "/R7"}, "busy cycles", cyc, exp_steps);
    check(g_id.size() == q_id.size(), req, "event count", g_id.size(), q_id.size());
    for (int i = 0; i < g_id.size() && i < q_id.size(); i++) begin
      check(g_id[i] == q_id[i], req, "event id", g_id[i], q_id[i]);
      check(g_en[i] == q_en[i], req, "event enable", g_en[i], q_en[i]);
    end
    read_check(r, req);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL R7 watchdog expired: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd41));
    for (int r = 0; r < 4; r++) m_reg[r] = '0;
    rst_n = 1'b0; addr = '0; wr_data = '0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check(busy == 1'b0, "R12", "busy after reset", busy, 0);
    check(ev_valid == 1'b0, "R12", "ev_valid after reset", ev_valid, 0);
    for (int r = 0; r < 4; r++) read_check(r, "R12");

    // R5 single mask field, R10 direct source with successor
    run_write(0, 0, 16'h8000, 3'd5, 0, "R5");
    run_write(0, 0, 16'h2000, 3'd0, 0, "R10");
    // R9 group chain 16->3->4->5, R1 alias clear
    run_write(1, 0, 16'h8000, 3'd7, 0, "R9");
    run_write(1, 1, 16'h8000, 3'd2, 0, "R1");
    // R8 id 0 and unused id 20
    run_write(0, 0, 16'h0001, 3'd0, 0, "R8");
    run_write(1, 0, 16'h2000, 3'd0, 0, "R8");
    // R2 set then clear of overlapping bits
    run_write(0, 0, 16'h0F0F, 3'd1, 0, "R2");
    run_write(0, 1, 16'h00FF, 3'd6, 0, "R2");
    // R6 priority field 0->3, 3->7 (nonzero to nonzero), clear
    run_write(2, 0, 16'h0300, 3'd0, 0, "R6");
    run_write(2, 0, 16'h0400, 3'd0, 0, "R6");
    run_write(2, 1, 16'h0700, 3'd3, 0, "R6");
    run_write(2, 0, 16'h0050, 3'd0, 0, "R6");
    // R3 set-only load, nested chain 18->19->12
    run_write(3, 2, 16'h1234, 3'd0, 0, "R3");
    run_write(3, 2, 16'h1000, 3'd4, 0, "R3");
    // R11 write during walk dropped
    run_write(0, 0, 16'hFFFF, 3'd0, 1, "R11");
    read_check(1, "R11");

    // R4 unmapped write and read
    @(negedge clk);
    addr = BASE + 32'h40;
    wr_data = 16'hFFFF;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check(busy == 1'b0, "R4", "busy after unmapped write", busy, 0);
    check(rd_data == 16'h0, "R4", "unmapped read", rd_data, 0);
    for (int r = 0; r < 4; r++) read_check(r, "R4");

    // random mix, R1/R2/R3/R5/R6/R9
    for (int i = 0; i < 120; i++) begin
      int r = int'($urandom % 4);
      int kind = (r == 3) ? 2 : int'($urandom % 2);
      logic [15:0] d = 16'($urandom);
      if (($urandom % 3) == 0) d = d & 16'($urandom);
      run_write(r, kind, d, 3'($urandom), 0, "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule